// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This controller gathers 128 level-sensitive request lines and turns them into one interrupt line for a processor. Each source can be disabled by its own mask bit and carries a 6-bit priority, where a smaller number is more urgent. A global threshold admits only sources whose priority value is strictly below it. Among the admitted requests, the controller picks the most urgent one. When two sources share the same priority, the lower source number wins.

Once the controller has picked a winner, it latches that source number, raises the interrupt line and stops arbitrating. It resumes only after software writes an acknowledge. The status word gives the latched source number. It also flags a spurious event: the latched source stopped being eligible before software read the status, or there is no interrupt active at all. Software reads the status, serves the source and then acknowledges. It must acknowledge a spurious event too, so that arbitration resumes.

Registers sit on a single-cycle word-addressed port. Read data is combinational from the address, and writes take effect at the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every priority is 0, the threshold is 64, the interrupt output is low and the status word reads 0xFFFFFF80.
- R2: Mask bits live in words at addresses 4 to 7. Source n uses word 4 + n/32, bit n mod 32. A 1 disables the source, and every mask word reads back the value last written.
- R3: The priority of source n is at word address 128 + n, in bits [5:0], and reads back. Among eligible sources the lowest priority value wins, and on a tie the lowest source number wins.
- R4: The threshold is at address 2, in bits [6:0], and reads back. A source is eligible only when it is requesting, unmasked, and its priority value is strictly less than the threshold.
- R5: While no interrupt is latched, an eligible source causes the interrupt output to be high in the next cycle. The status word at address 0 then carries the winner's number in bits [6:0].
- R6: While an interrupt is latched, the source number and the high output stay unchanged until an acknowledge. An acknowledge is a write to address 1 with bit 0 set. After it the output is low for at least one cycle, and only then can a new winner be latched.
- R7: Status bits [31:7] read all ones once the latched source has stopped being eligible (dropped, masked or shut out by the threshold) at any point before its status is read. The flag stays set until acknowledge. Losing eligibility after a status read does not set it.
- R8: With no interrupt latched, status reads 0xFFFFFF80 (spurious pattern, source 0).
- R9: A write to address 1 with bit 0 clear has no effect on the latched interrupt.
- R10: Address 1, unused addresses 3 and 8 to 127 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_req | input | 128 | Level-sensitive request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Several corner cases are targeted directly:
- Equal-priority ties. A design that favoured the higher index would report the wrong source.
- A request that arrives while another source is latched. A design that kept arbitrating would swap the source number under software.
- Eligibility lost before and after the status read. A flag that was not sticky, or that ignored the read, would misreport spurious events.
- A threshold equal to a source's priority. An off-by-one comparison would let that source through.
- The cycle right after an acknowledge. A design that re-latched in the same edge would never drop the line.

A long random phase mixes mask, priority and threshold writes, acknowledges and request toggles against the behavioural model.

// File: rtl/irq_ctrl_pkg.sv
// Package: register map constants shared by the interrupt controller.
// Assumes word addressing on the register port.
package irq_ctrl_pkg;
    localparam int STATUS_ADDR = 0;    // active source and spurious flag
    localparam int CTRL_ADDR   = 1;    // bit 0 = acknowledge
    localparam int THR_ADDR    = 2;    // priority threshold
    localparam int MASK_BASE   = 4;    // first mask word
    localparam int PRIO_BASE   = 128;  // first per-source priority word
endpackage

// File: rtl/irq_regs.sv
// Module: configuration storage (mask words, priorities, threshold) with
// the read mux for those registers. Assumes a single-cycle write strobe,
// NUM_SRC a multiple of DATA_W and the priority window fitting in ADDR_W.
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 6,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int THR_W  = PRIO_W + 1,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int MASK_WORDS = NUM_SRC / DATA_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [DATA_W-1:0]                    wdata_i,
    output logic [MASK_WORDS-1:0][DATA_W-1:0]    mask_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]       prio_o,
    output logic [THR_W-1:0]                     thr_o,
    output logic [DATA_W-1:0]                    rdata_o
);
    localparam int MW_W = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1;
    localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(THR_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(PRIO_BASE);
    localparam logic [THR_W-1:0]  THR_OPEN = THR_W'(1 << PRIO_W);

    logic [ADDR_W-1:0] moff, poff;
    logic              in_mask, in_prio, is_thr;
    logic [MW_W-1:0]   midx;
    logic [ID_W-1:0]   pidx;

    // Decode the address into a register class and an index.
    always_comb begin
        moff    = addr_i - A_MASK;
        poff    = addr_i - A_PRIO;
        in_mask = (addr_i >= A_MASK) && (moff < ADDR_W'(MASK_WORDS));
        in_prio = (addr_i >= A_PRIO) && (poff < ADDR_W'(NUM_SRC));
        is_thr  = (addr_i == A_THR);
        midx    = moff[MW_W-1:0];
        pidx    = poff[ID_W-1:0];
    end

    // Mask words: reset to all-disabled, whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '1;
        else if (wr_en_i && in_mask)
            mask_o[midx] <= wdata_i;
    end

    // Per-source priorities: reset to most urgent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_o <= '0;
        else if (wr_en_i && in_prio)
            prio_o[pidx] <= wdata_i[PRIO_W-1:0];
    end

    // Threshold: reset to a value every priority passes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_o <= THR_OPEN;
        else if (wr_en_i && is_thr)
            thr_o <= wdata_i[THR_W-1:0];
    end

    // Read mux for the configuration registers.
    always_comb begin
        rdata_o = '0;
        if (in_mask)
            rdata_o = mask_o[midx];
        else if (in_prio)
            rdata_o = DATA_W'(prio_o[pidx]);
        else if (is_thr)
            rdata_o = DATA_W'(thr_o);
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && in_mask) |=> (mask_o[$past(midx)] == $past(wdata_i))); // R2
    AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && is_thr) |=> (thr_o == $past(wdata_i[THR_W-1:0]))); // R4
endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational eligibility and priority selection.
// Assumes priority 0 is most urgent; equal priorities resolve to the
// lowest source number. Threshold passes a source only when prio < thr.
module irq_arbiter #(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 6,
    localparam int THR_W  = PRIO_W + 1,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0]             mask_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]               thr_i,
    output logic [NUM_SRC-1:0]             elig_o,
    output logic                           any_o,
    output logic [ID_W-1:0]                win_o
);
    // One eligibility term per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig_o[g] = req_i[g] & ~mask_i[g] & ({1'b0, prio_i[g]} < thr_i);
    end

    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_i;

    // Scan upward, replacing only on a strictly better priority.
    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_o[i] && (!found || (prio_i[i] < best_p))) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = ID_W'(i);
            end
        end
    end

    assign any_o = found;
    assign win_o = best_i;
endmodule

// File: rtl/irq_latch.sv
// Module: holds the winning source until acknowledge and tracks the
// spurious condition. Assumes cur_valid_i reflects the latched source's
// present eligibility and stat_rd_i pulses on a status read.
module irq_latch #(
    parameter int ID_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_i,
    input  logic [ID_W-1:0] win_i,
    input  logic            ack_i,
    input  logic            stat_rd_i,
    input  logic            cur_valid_i,
    output logic            busy_o,
    output logic [ID_W-1:0] id_o,
    output logic            spur_o
);
    logic spur_q, seen_q;

    // Latch, hold and release the active source; record invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            id_o   <= '0;
            spur_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (ack_i) begin
            busy_o <= 1'b0;
            spur_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (!busy_o) begin
            if (any_i) begin
                busy_o <= 1'b1;
                id_o   <= win_i;
            end
        end else begin
            if (!seen_q && !cur_valid_i)
                spur_q <= 1'b1;
            if (stat_rd_i)
                seen_q <= 1'b1;
        end
    end

    // Spurious when idle, when already flagged, or when invalid before a read.
    assign spur_o = !busy_o || spur_q || (!seen_q && !cur_valid_i);

    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_i) |=> (busy_o && $stable(id_o))); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !busy_o); // R6
    AST_LATCH_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ack_i && any_i) |=> busy_o); // R5
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !any_i) |=> !busy_o); // R5
    AST_SPUR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && spur_q && !ack_i) |=> spur_o); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the prioritized interrupt controller. Decodes the
// register port, ties storage, arbiter and latch together and forms the
// status word. Assumes a single-cycle register port with combinational
// read data and level-sensitive requests.
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 6,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               irq_out
);
    localparam int THR_W      = PRIO_W + 1;
    localparam int ID_W       = $clog2(NUM_SRC);
    localparam int MASK_WORDS = NUM_SRC / DATA_W;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

    logic [MASK_WORDS-1:0][DATA_W-1:0] mask_w;
    logic [NUM_SRC-1:0][PRIO_W-1:0]    prio;
    logic [THR_W-1:0]                  thr;
    logic [DATA_W-1:0]                 cfg_rdata;
    logic [NUM_SRC-1:0]                elig;
    logic                              any_elig, busy, spur;
    logic [ID_W-1:0]                   win, act_id;
    logic                              ack, stat_rd;

    // Bus strobes for acknowledge and status read.
    assign ack     = bus_sel & bus_wr & (bus_addr == A_CTRL) & bus_wdata[0];
    assign stat_rd = bus_sel & ~bus_wr & (bus_addr == A_STAT);

    irq_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(bus_sel & bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .mask_o(mask_w), .prio_o(prio), .thr_o(thr), .rdata_o(cfg_rdata)
    );

    irq_arbiter #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_arb (
        .req_i(irq_req), .mask_i(mask_w), .prio_i(prio), .thr_i(thr),
        .elig_o(elig), .any_o(any_elig), .win_o(win)
    );

    irq_latch #(
        .ID_W(ID_W)
    ) u_latch (
        .clk(clk), .rst_n(rst_n),
        .any_i(any_elig), .win_i(win), .ack_i(ack), .stat_rd_i(stat_rd),
        .cur_valid_i(elig[act_id]),
        .busy_o(busy), .id_o(act_id), .spur_o(spur)
    );

    // Status word and final read mux.
    always_comb begin
        if (bus_addr == A_STAT)
            bus_rdata = {{(DATA_W-ID_W){spur}}, busy ? act_id : ID_W'(0)};
        else
            bus_rdata = cfg_rdata;
    end

    assign irq_out = busy;

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> irq_out); // R6
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic         clk = 1'b0;
    logic         rst_n, sel, wr;
    logic [7:0]   addr;
    logic [31:0]  wdata, rdata;
    logic [127:0] req;
    logic         irq;

    always #5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(req), .irq_out(irq)
    );

    // Behavioural reference state.
    bit m_mask [128];
    int m_prio [128];
    int m_thr;
    bit m_busy, m_spur, m_seen;
    int m_id;
    int checks = 0, fails = 0;
    bit done = 0;

    function automatic bit m_elig(int n);
        return req[n] && !m_mask[n] && (m_prio[n] < m_thr);
    endfunction

    function automatic int m_win();
        int best = -1;
        for (int n = 0; n < 128; n++)
            if (m_elig(n) && (best < 0 || m_prio[n] < m_prio[best])) best = n;
        return best;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v = 0;
        if (a == 0) begin
            if (!m_busy) v = 32'hFFFF_FF80;
            else if (m_spur || (!m_seen && !m_elig(m_id))) v = 32'hFFFF_FF80 | m_id;
            else v = m_id;
        end else if (a == 2) v = m_thr;
        else if (a >= 4 && a <= 7) begin
            for (int b = 0; b < 32; b++) v[b] = m_mask[(a-4)*32 + b];
        end else if (a >= 128) v = m_prio[a-128];
        return v;
    endfunction

    function automatic string tag_of(int a);
        if (a == 0) return "R7";
        if (a == 2) return "R4";
        if (a >= 4 && a <= 7) return "R2";
        if (a >= 128) return "R3";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic m_reset();
        for (int n = 0; n < 128; n++) begin m_mask[n] = 1; m_prio[n] = 0; end
        m_thr = 64; m_busy = 0; m_spur = 0; m_seen = 0; m_id = 0;
    endtask

    task automatic m_update();
        bit ack, srd, valid;
        int w;
        ack   = sel && wr && addr == 1 && wdata[0];
        srd   = sel && !wr && addr == 0;
        valid = m_elig(m_id);
        w     = m_win();
        if (ack) begin
            m_busy = 0; m_spur = 0; m_seen = 0;
        end else if (!m_busy) begin
            if (w >= 0) begin m_busy = 1; m_id = w; end
        end else begin
            if (!m_seen && !valid) m_spur = 1;
            if (srd) m_seen = 1;
        end
        if (sel && wr) begin
            if (addr == 2) m_thr = int'(wdata[6:0]);
            else if (addr >= 4 && addr <= 7)
                for (int b = 0; b < 32; b++) m_mask[(addr-4)*32 + b] = wdata[b];
            else if (addr >= 128) m_prio[addr-128] = int'(wdata[5:0]);
        end
    endtask

    // One clock: compare at mid-low phase, then advance the model at the edge.
    task automatic cyc(string tag);
        #1;
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_busy});
        if (sel && !wr) chk(tag, rdata, m_read(int'(addr)));
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        sel = 0; wr = 0;
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr_reg(int a, logic [31:0] d, string tag);
        sel = 1; wr = 1; addr = 8'(a); wdata = d;
        cyc(tag);
        sel = 0; wr = 0;
    endtask

    task automatic rd_reg(int a, string tag);
        sel = 1; wr = 0; addr = 8'(a);
        cyc(tag);
        sel = 0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R6: watchdog expired, got hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0; req = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 / R8: reset values
        rd_reg(0, "R1");
        rd_reg(0, "R8");
        rd_reg(2, "R1");
        for (int a = 4; a < 8; a++) rd_reg(a, "R1");
        rd_reg(133, "R1");

        // R2: masked sources cannot interrupt
        req[40] = 1; req[3] = 1; req[100] = 1;
        idle(3, "R2");
        wr_reg(5, ~(32'd1 << 8), "R2");
        rd_reg(5, "R2");
        idle(1, "R5");
        rd_reg(0, "R5");

        // R6 / R9: hold through new requests and non-ack writes
        wr_reg(4, ~(32'd1 << 3), "R6");
        idle(2, "R6");
        rd_reg(0, "R6");
        wr_reg(1, 32'h0000_0000, "R9");
        idle(1, "R9");
        rd_reg(0, "R9");
        wr_reg(1, 32'h1, "R6");
        idle(1, "R6");
        rd_reg(0, "R3");
        wr_reg(1, 32'h1, "R6");

        // R3: priority ordering and read-back
        wr_reg(128 + 3, 5, "R3");
        wr_reg(128 + 40, 5, "R3");
        wr_reg(128 + 100, 32'hFFFF_FFC2, "R3");
        wr_reg(7, ~(32'd1 << 4), "R3");
        rd_reg(128 + 100, "R3");
        wr_reg(1, 32'h1, "R3");
        idle(1, "R3");
        rd_reg(0, "R3");

        // R4 / R7: threshold equal to priority blocks the source
        wr_reg(2, 2, "R4");
        rd_reg(0, "R7");
        wr_reg(1, 32'h1, "R7");
        idle(3, "R4");
        rd_reg(0, "R8");
        wr_reg(2, 3, "R4");
        rd_reg(2, "R4");
        idle(1, "R4");
        rd_reg(0, "R4");

        // R7: request drops before the read, flag sticks
        req[100] = 0;
        idle(1, "R7");
        rd_reg(0, "R7");
        req[100] = 1;
        rd_reg(0, "R7");
        wr_reg(1, 32'h1, "R7");
        idle(1, "R7");
        rd_reg(0, "R7");
        req[100] = 0;
        idle(1, "R7");
        rd_reg(0, "R7");
        req[100] = 1;
        wr_reg(1, 32'h1, "R7");
        idle(1, "R7");
        wr_reg(7, 32'hFFFF_FFFF, "R7");
        rd_reg(0, "R7");
        wr_reg(1, 32'h1, "R7");

        // R10: unmapped and control reads
        rd_reg(1, "R10");
        rd_reg(3, "R10");
        rd_reg(8, "R10");
        rd_reg(127, "R10");

        // Random phase compared against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            int op, a;
            if ($urandom % 3 == 0) req[$urandom % 128] ^= 1'b1;
            op = $urandom % 10;
            sel = 0; wr = 0;
            if (op == 0) begin sel = 1; wr = 0; addr = 0; end
            else if (op == 1) begin
                a = ($urandom % 2) ? 128 + ($urandom % 128) : ($urandom % 10);
                sel = 1; wr = 0; addr = 8'(a);
            end else if (op == 2) begin
                sel = 1; wr = 1; addr = 8'(4 + $urandom % 4);
                wdata = $urandom | $urandom;
            end else if (op == 3) begin
                sel = 1; wr = 1; addr = 8'(4 + $urandom % 4);
                wdata = $urandom & $urandom & $urandom;
            end else if (op == 4) begin
                sel = 1; wr = 1; addr = 8'(128 + $urandom % 128); wdata = $urandom;
            end else if (op == 5) begin
                sel = 1; wr = 1; addr = 2; wdata = 32'($urandom % 66);
            end else if (op == 6) begin
                sel = 1; wr = 1; addr = 1; wdata = $urandom;
            end
            a = int'(addr);
            cyc((sel && !wr) ? tag_of(a) : "R5");
        end
        idle(2, "R6");

        done = 1;
        report();
        $finish;
    end
endmodule